// File: doc/BRIEF.md
# Iterative Long Integer Multiplier

This block is a multi-cycle multiply engine for a 32-bit integer execution pipe. It accepts two 32-bit source operands, a 64-bit addend supplied as separate low and high words, and a 3-bit operation code. It returns either the low 32 bits of the product or a full 64-bit product, optionally summed with the addend, as two 32-bit result words.

The multiplier operand (`src_b`) is consumed one 8-bit digit per cycle. Iteration stops as soon as the digits still unprocessed carry no further information. For unsigned work this means they are all zero. For signed work it means they are pure sign extension. The run therefore lasts 1 to 4 cycles.

A caller raises `start` for one cycle while `busy` is low. It then waits for the single-cycle `done` pulse and reads `res_lo` and `res_hi`, which hold until the next completion. The block has no register file access, no decode and no flag generation.

Operation code `op`:

| op[2] `long` | op[1] `signed` | op[0] `accumulate` | Operation |
|---|---|---|---|
| 0 | ignored | ignored | Short multiply: low 32 bits of the product only |
| 1 | 0 | 0 | Unsigned long multiply |
| 1 | 1 | 0 | Signed long multiply |
| 1 | 0 | 1 | Unsigned long multiply-accumulate |
| 1 | 1 | 1 | Signed long multiply-accumulate |

Top module: `lmul_top`

## Requirements
- R1: When op[2]=0 (short multiply), `res_lo` equals bits 31:0 of `src_a`×`src_b`. `res_hi` is 0. op[1], op[0], `acc_lo` and `acc_hi` have no effect on the result or on the latency.
- R2: op=3'b100 gives {`res_hi`,`res_lo`} = `src_a`×`src_b`, with both operands taken as unsigned. `res_lo` carries bits 31:0 and `res_hi` carries bits 63:32.
- R3: op=3'b110 gives {`res_hi`,`res_lo`} = `src_a`×`src_b`, with both operands taken as two's complement.
- R4: op[2]=1 with op[0]=1 adds {`acc_hi`,`acc_lo`} to the 64-bit product selected by op[1]. The sum wraps modulo 2^64 and no overflow is reported.
- R5: For the short and unsigned forms, `done` rises N clock edges after the edge that accepts `start`. N is 1 if `src_b` < 2^8, 2 if `src_b` < 2^16, 3 if `src_b` < 2^24, and 4 otherwise.
- R6: For the signed long forms, N is the smallest of 1..4 for which `src_b`, read as two's complement, lies in [-2^(8N-1), 2^(8N-1)).
- R7: `start` is taken only while `busy` is low. That includes the cycle in which `done` is high. `busy` is high from the cycle after acceptance until the completion cycle, and is low while `done` is high. A `start` raised while `busy` is high changes neither the result nor the number of `done` pulses.
- R8: `done` is high for exactly one cycle per accepted operation. `res_lo` and `res_hi` change only in a cycle where `done` is high and hold their values otherwise.
- R9: While `rst_n` is low, `busy`, `done`, `res_lo` and `res_hi` are 0, and an operation in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| start | input | 1 | Begin an operation; sampled only while `busy` is low |
| op | input | 3 | Operation code {long, signed, accumulate} |
| src_a | input | 32 | Multiplicand |
| src_b | input | 32 | Multiplier; its value sets the iteration count |
| acc_lo | input | 32 | Addend bits 31:0 |
| acc_hi | input | 32 | Addend bits 63:32 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32; 0 for the short form |

## Verification
A mistake in the partial-sum, multiplicand or remaining-digit registers cannot stay hidden. It reaches `res_lo`/`res_hi` at the `done` pulse of the same operation, at most four cycles after `start`, and it does not show before then because the result words are held. A wrong early-exit decision shows as `done` arriving one or more cycles early or late. It usually also gives a corrupted high word, because a digit is dropped or double-counted, or a signed top digit is read as unsigned. A stuck control state shows either as `busy` that never drops or as a second `done` pulse one cycle after the first.

// File: rtl/lmul_pkg.sv
package lmul_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lmul_state_e;

  // Operation code layout, most significant bit first.
  typedef struct packed {
    logic is_long;
    logic is_signed;
    logic accum;
  } lmul_op_t;

  function automatic lmul_op_t lmul_decode(input logic [2:0] code);
    return lmul_op_t'(code);
  endfunction

endpackage

// File: rtl/lmul_digit.sv
// Selects the current multiplier digit and decides whether it is the last one.
module lmul_digit #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic [DATA_W:0]    rem,
  input  logic               signed_mode,
  output logic [DIGIT_W-1:0] dig_mag,
  output logic               dig_neg,
  output logic               last
);

  localparam int UP_U_W = DATA_W + 1 - DIGIT_W;
  localparam int UP_S_W = UP_U_W + 1;

  logic [UP_U_W-1:0] upper_u;
  logic [UP_S_W-1:0] upper_s;
  logic              last_u;
  logic              last_s;

  always_comb begin
    upper_u = rem[DATA_W:DIGIT_W];
    upper_s = rem[DATA_W:DIGIT_W-1];
    // Unsigned: nothing left above this digit.
    last_u  = ~(|upper_u);
    // Signed: this digit's top bit and everything above are one sign run.
    last_s  = (&upper_s) | ~(|upper_s);
    last    = signed_mode ? last_s : last_u;
    dig_mag = rem[DIGIT_W-1:0];
    // Final signed digit carries weight -2^DIGIT_W on its top bit.
    dig_neg = signed_mode & last & rem[DIGIT_W-1];
  end

endmodule

// File: rtl/lmul_datapath.sv
// Partial-sum, shifted multiplicand and remaining-multiplier registers.
module lmul_datapath
  import lmul_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  lmul_op_t              op,
  input  logic [DATA_W-1:0]     src_a,
  input  logic [DATA_W-1:0]     src_b,
  input  logic [DATA_W-1:0]     acc_lo,
  input  logic [DATA_W-1:0]     acc_hi,
  input  logic [DIGIT_W-1:0]    dig_mag,
  input  logic                  dig_neg,
  output logic [DATA_W:0]       rem,
  output logic                  signed_mode,
  output logic                  long_mode,
  output logic [2*DATA_W-1:0]   sum_nxt
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int REM_W  = DATA_W + 1;

  logic [PROD_W-1:0] prod_q,  prod_n;
  logic [PROD_W-1:0] mcand_q, mcand_n;
  logic [REM_W-1:0]  rem_q,   rem_n;
  logic              sgn_q,   sgn_n;
  logic              long_q,  long_n;

  logic              sgn_eff;
  logic              acc_eff;
  logic [PROD_W-1:0] partial;
  logic [PROD_W-1:0] neg_term;

  // Next-state logic
  always_comb begin
    sgn_eff  = op.is_long & op.is_signed;
    acc_eff  = op.is_long & op.accum;
    neg_term = dig_neg ? (mcand_q << DIGIT_W) : '0;
    partial  = (mcand_q * PROD_W'(dig_mag)) - neg_term;
    sum_nxt  = prod_q + partial;

    prod_n  = prod_q;
    mcand_n = mcand_q;
    rem_n   = rem_q;
    sgn_n   = sgn_q;
    long_n  = long_q;

    if (load) begin
      prod_n  = acc_eff ? {acc_hi, acc_lo} : '0;
      mcand_n = sgn_eff ? {{DATA_W{src_a[DATA_W-1]}}, src_a}
                        : {{DATA_W{1'b0}}, src_a};
      rem_n   = {sgn_eff & src_b[DATA_W-1], src_b};
      sgn_n   = sgn_eff;
      long_n  = op.is_long;
    end else if (step) begin
      prod_n  = sum_nxt;
      mcand_n = mcand_q << DIGIT_W;
      rem_n   = REM_W'($signed(rem_q) >>> DIGIT_W);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      mcand_q <= '0;
      rem_q   <= '0;
      sgn_q   <= 1'b0;
      long_q  <= 1'b0;
    end else if (load | step) begin
      prod_q  <= prod_n;
      mcand_q <= mcand_n;
      rem_q   <= rem_n;
      sgn_q   <= sgn_n;
      long_q  <= long_n;
    end
  end

  assign rem         = rem_q;
  assign signed_mode = sgn_q;
  assign long_mode   = long_q;

endmodule

// File: rtl/lmul_ctrl.sv
// Idle/run sequencing with a hard cap on the digit count.
module lmul_ctrl
  import lmul_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  lmul_state_e      state_q, state_n;
  logic [CNT_W-1:0] iter_q,  iter_n;
  logic             done_q,  done_n;
  logic             cap;

  // Next-state logic
  always_comb begin
    load    = (state_q == ST_IDLE) & start;
    step    = (state_q == ST_RUN);
    cap     = (iter_q == CNT_W'(NUM_DIGITS - 1));
    finish  = step & (last | cap);
    state_n = state_q;
    iter_n  = iter_q;
    done_n  = finish;

    if (load) begin
      state_n = ST_RUN;
      iter_n  = '0;
    end else if (finish) begin
      state_n = ST_IDLE;
      iter_n  = '0;
    end else if (step) begin
      iter_n  = iter_q + CNT_W'(1);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      iter_q  <= iter_n;
      done_q  <= done_n;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

endmodule

// File: rtl/lmul_top.sv
module lmul_top
  import lmul_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic [DATA_W-1:0] acc_hi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi
);

  localparam int NUM_DIGITS = (DATA_W + DIGIT_W - 1) / DIGIT_W;
  localparam int PROD_W     = 2 * DATA_W;

  lmul_op_t          op_dec;
  logic              load, step, finish, last;
  logic [DATA_W:0]   rem;
  logic              signed_mode, long_mode;
  logic [DIGIT_W-1:0] dig_mag;
  logic              dig_neg;
  logic [PROD_W-1:0] sum_nxt;

  logic [DATA_W-1:0] res_lo_q, res_lo_n;
  logic [DATA_W-1:0] res_hi_q, res_hi_n;

  assign op_dec = lmul_decode(op);

  lmul_ctrl #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .last   (last),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  lmul_digit #(
    .DATA_W  (DATA_W),
    .DIGIT_W (DIGIT_W)
  ) u_digit (
    .rem         (rem),
    .signed_mode (signed_mode),
    .dig_mag     (dig_mag),
    .dig_neg     (dig_neg),
    .last        (last)
  );

  lmul_datapath #(
    .DATA_W  (DATA_W),
    .DIGIT_W (DIGIT_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .step        (step),
    .op          (op_dec),
    .src_a       (src_a),
    .src_b       (src_b),
    .acc_lo      (acc_lo),
    .acc_hi      (acc_hi),
    .dig_mag     (dig_mag),
    .dig_neg     (dig_neg),
    .rem         (rem),
    .signed_mode (signed_mode),
    .long_mode   (long_mode),
    .sum_nxt     (sum_nxt)
  );

  // Result next-state
  always_comb begin
    res_lo_n = res_lo_q;
    res_hi_n = res_hi_q;
    if (finish) begin
      res_lo_n = sum_nxt[DATA_W-1:0];
      res_hi_n = long_mode ? sum_nxt[PROD_W-1:DATA_W] : '0;
    end
  end

  // Result registers, enabled on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo_q <= '0;
      res_hi_q <= '0;
    end else if (finish) begin
      res_lo_q <= res_lo_n;
      res_hi_q <= res_hi_n;
    end
  end

  assign res_lo = res_lo_q;
  assign res_hi = res_hi_q;

endmodule

// File: rtl/lmul_chk.sv
module lmul_chk #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        op,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] acc_lo,
  input logic [DATA_W-1:0] acc_hi,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] res_lo,
  input logic [DATA_W-1:0] res_hi
);

  localparam int NUM_DIGITS = (DATA_W + DIGIT_W - 1) / DIGIT_W;
  localparam int PROD_W     = 2 * DATA_W;

  logic [2:0]        op_c;
  logic [DATA_W-1:0] a_c, b_c;
  logic [PROD_W-1:0] acc_c;
  int unsigned       cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_c  <= '0;
      a_c   <= '0;
      b_c   <= '0;
      acc_c <= '0;
      cnt   <= 0;
    end else if (start && !busy) begin
      op_c  <= op;
      a_c   <= src_a;
      b_c   <= src_b;
      acc_c <= {acc_hi, acc_lo};
      cnt   <= 0;
    end else if (busy) begin
      cnt   <= cnt + 1;
    end
  end

  logic signed [PROD_W-1:0] sa, sb;
  logic [PROD_W-1:0]        ua, ub, pu, ps, expv;

  always_comb begin
    sa = {{DATA_W{a_c[DATA_W-1]}}, a_c};
    sb = {{DATA_W{b_c[DATA_W-1]}}, b_c};
    ua = {{DATA_W{1'b0}}, a_c};
    ub = {{DATA_W{1'b0}}, b_c};
    pu = ua * ub;
    ps = PROD_W'(sa * sb);
    if (op_c[2])
      expv = (op_c[1] ? ps : pu) + (op_c[0] ? acc_c : '0);
    else
      expv = {{DATA_W{1'b0}}, pu[DATA_W-1:0]};
  end

  function automatic int unsigned want_lat(input logic [DATA_W-1:0] b, input logic sgn);
    for (int n = 1; n <= NUM_DIGITS; n++) begin
      if (sgn) begin
        logic signed [DATA_W-1:0] t;
        t = $signed(b) >>> (n * DIGIT_W - 1);
        if (t == 0 || t == -1) return n;
      end else begin
        if ((PROD_W'(b) >> (n * DIGIT_W)) == 0) return n;
      end
    end
    return NUM_DIGITS;
  endfunction

  // R1
  p_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_c[2]) |-> (res_hi == '0 && res_lo == expv[DATA_W-1:0]));
  // R2
  p_umul_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_c == 3'b100) |-> ({res_hi, res_lo} == expv));
  // R3
  p_smul_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_c == 3'b110) |-> ({res_hi, res_lo} == expv));
  // R4
  p_accum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_c[2] && op_c[0]) |-> ({res_hi, res_lo} == expv));
  // R5
  p_lat_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(op_c[2] && op_c[1])) |-> (cnt == want_lat(b_c, 1'b0)));
  // R6
  p_lat_signed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_c[2] && op_c[1]) |-> (cnt == want_lat(b_c, 1'b1)));
  // R6: run never exceeds the digit count
  p_lat_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < NUM_DIGITS));
  // R7
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_lo) && $stable(res_hi)));
  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r9: assert (!busy && !done && res_lo == '0 && res_hi == '0);
    end
  end

endmodule

bind lmul_top lmul_chk #(
  .DATA_W  (DATA_W),
  .DIGIT_W (DIGIT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .op     (op),
  .src_a  (src_a),
  .src_b  (src_b),
  .acc_lo (acc_lo),
  .acc_hi (acc_hi),
  .busy   (busy),
  .done   (done),
  .res_lo (res_lo),
  .res_hi (res_hi)
);

// File: tb/sim_lmul_top.sv
`timescale 1ns/1ps
module sim_lmul_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [31:0] src_a, src_b, acc_lo, acc_hi;
  logic        busy, done;
  logic [31:0] res_lo, res_hi;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  lmul_top u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .src_a  (src_a),
    .src_b  (src_b),
    .acc_lo (acc_lo),
    .acc_hi (acc_hi),
    .busy   (busy),
    .done   (done),
    .res_lo (res_lo),
    .res_hi (res_hi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] alo;
    logic [31:0] ahi;
    logic [31:0] elo;
    logic [31:0] ehi;
    logic [2:0]  lat;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 32'h00000002, 32'h00000002, 32'h0, 32'h0, 32'h00000004, 32'h00000000, 3'd1},
    '{3'b100, 32'hF0000002, 32'h00000002, 32'h0, 32'h0, 32'hE0000004, 32'h00000001, 3'd1},
    '{3'b100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h00000001, 32'hFFFFFFFE, 3'd4},
    '{3'b110, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h00000001, 32'h00000000, 3'd1},
    '{3'b110, 32'h00000003, 32'hFFFFFFFE, 32'h0, 32'h0, 32'hFFFFFFFA, 32'hFFFFFFFF, 3'd1},
    '{3'b110, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 32'h00000000, 32'h40000000, 3'd4},
    '{3'b100, 32'h00000100, 32'h00010000, 32'h0, 32'h0, 32'h01000000, 32'h00000000, 3'd3},
    '{3'b110, 32'h00000010, 32'h00000080, 32'h0, 32'h0, 32'h00000800, 32'h00000000, 3'd2},
    '{3'b100, 32'h00000010, 32'h00000080, 32'h0, 32'h0, 32'h00000800, 32'h00000000, 3'd1},
    '{3'b101, 32'h00000002, 32'h00000003, 32'hFFFFFFFF, 32'h00000001, 32'h00000005, 32'h00000002, 3'd1},
    '{3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 3'd1},
    '{3'b101, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h00000000, 3'd4},
    '{3'b011, 32'hFFFFFFFF, 32'h00000003, 32'h9ABCDEF0, 32'h12345678, 32'hFFFFFFFD, 32'h00000000, 3'd1},
    '{3'b000, 32'h12345678, 32'h01000000, 32'h0, 32'h0, 32'h78000000, 32'h00000000, 3'd4},
    '{3'b110, 32'h00000001, 32'hFFFF7FFF, 32'h0, 32'h0, 32'hFFFF7FFF, 32'hFFFFFFFF, 3'd3},
    '{3'b100, 32'h00000001, 32'h00000000, 32'h0, 32'h0, 32'h00000000, 32'h00000000, 3'd1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Launches one operation and waits for done; lat counts edges after acceptance.
  task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] alo, input logic [31:0] ahi,
                        output logic [31:0] lo, output logic [31:0] hi, output int lat);
    @(negedge clk);
    op = o; src_a = a; src_b = b; acc_lo = alo; acc_hi = ahi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after accept", 64'(busy), 64'd1);
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
    check(done == 1'b1, "R8", "done seen", 64'(done), 64'd1);
    check(busy == 1'b0, "R7", "busy low with done", 64'(busy), 64'd0);
    lo = res_lo;
    hi = res_hi;
  endtask

  initial begin
    #1000000;
    $display("FAIL watchdog expired actual=running expected=finished");
    errors++;
    finish_run();
  end

  initial begin
    logic [31:0] lo, hi;
    int lat;
    string req, lreq;
    int dones;

    rst_n = 1'b0; start = 1'b0; op = '0;
    src_a = '0; src_b = '0; acc_lo = '0; acc_hi = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 0 && done == 0, "R9", "busy/done in reset", {62'd0, busy, done}, 64'd0);
    check({res_hi, res_lo} == 64'd0, "R9", "results in reset", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1..R6
    for (int k = 0; k < NV; k++) begin
      run_op(VECS[k].op, VECS[k].a, VECS[k].b, VECS[k].alo, VECS[k].ahi, lo, hi, lat);
      if (!VECS[k].op[2])      req = "R1";
      else if (VECS[k].op[0])  req = "R4";
      else if (VECS[k].op[1])  req = "R3";
      else                     req = "R2";
      lreq = (VECS[k].op[2] && VECS[k].op[1]) ? "R6" : "R5";
      check({hi, lo} == {VECS[k].ehi, VECS[k].elo}, req, $sformatf("result vec %0d", k),
            {hi, lo}, {VECS[k].ehi, VECS[k].elo});
      check(lat == int'(VECS[k].lat), lreq, $sformatf("latency vec %0d", k),
            64'(lat), 64'(VECS[k].lat));
    end

    // R8: done is one cycle, results hold afterwards
    run_op(3'b100, 32'h00000007, 32'h00000006, 32'h0, 32'h0, lo, hi, lat);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(done == 1'b0, "R8", "done dropped", 64'(done), 64'd0);
      check({res_hi, res_lo} == 64'd42, "R8", "result held", {res_hi, res_lo}, 64'd42);
    end

    // R7: start while busy is ignored
    @(negedge clk);
    op = 3'b100; src_a = 32'h3; src_b = 32'h01000000; acc_lo = 0; acc_hi = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op = 3'b000; src_a = 32'h5; src_b = 32'h5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "still busy after ignored start", 64'(busy), 64'd1);
    dones = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 1, "R7", "single done", 64'(dones), 64'd1);
    check({res_hi, res_lo} == 64'h03000000, "R7", "first result kept",
          {res_hi, res_lo}, 64'h03000000);
    check(busy == 1'b0, "R7", "idle after run", 64'(busy), 64'd0);

    // R7: start accepted in the done cycle
    @(negedge clk);
    op = 3'b100; src_a = 32'd7; src_b = 32'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b1 && res_lo == 32'd42, "R7", "first of pair",
          {31'd0, done, res_lo}, {31'd0, 1'b1, 32'd42});
    op = 3'b100; src_a = 32'd9; src_b = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R7", "accepted in done cycle",
          {62'd0, busy, done}, {62'd0, 2'b10});
    @(negedge clk);
    check(done == 1'b1 && res_lo == 32'd81, "R7", "second of pair",
          {31'd0, done, res_lo}, {31'd0, 1'b1, 32'd81});

    // R9: reset abandons a run
    @(negedge clk);
    op = 3'b110; src_a = 32'h80000000; src_b = 32'h80000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 0 && done == 0, "R9", "busy/done after mid-run reset",
          {62'd0, busy, done}, 64'd0);
    check({res_hi, res_lo} == 64'd0, "R9", "results after mid-run reset",
          {res_hi, res_lo}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    dones = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done || busy) dones++;
    end
    check(dones == 0, "R9", "no completion after reset", 64'(dones), 64'd0);

    finish_run();
  end

endmodule